// File: doc/BRIEF.md
# Discontinuous-Conduction Detector with Hysteresis

This block watches a switching converter's duty values and reports when the converter has entered discontinuous conduction. In continuous conduction, the synchronous-rectifier on-time `Db` equals the complement of the main on-time, `1 − Da`. In discontinuous conduction it falls short of that complement. Once per switching period, on a compare strobe, the block compares `Db` against this moving reference. A low margin and a high margin give independent set and clear points, so an operating point near the boundary does not make the indication chatter.

Three indications are produced. The first is a raw detect level. The second is a sticky interrupt status bit, which records each new entry into discontinuous mode while interrupts are enabled. The third is an interrupt line, which is that status qualified by the enable. A write-one pulse on the clear input drops the sticky status.

Top module: `dcm_detector`

## Requirements
- R1: All duty and limit inputs are 14-bit unsigned fractions of full scale 16384. The complement reference is formed as 16384 − Da.
- R2: On a cycle with the strobe high, the raw bit is set at that clock edge when Db < (16384 − Da) − lim_lo. Equality does not set it.
- R3: On a cycle with the strobe high, the raw bit is cleared at that clock edge when Db > (16384 − Da) + lim_hi. Equality does not clear it.
- R4: On a strobe where Db lies between the two thresholds, both inclusive, the raw bit keeps its previous value.
- R5: The raw bit is registered and changes only at a clock edge where the strobe is high. Without the strobe, the Da, Db and limit inputs have no effect.
- R6: Threshold arithmetic is carried out in a signed range wider than 14 bits. A lower threshold below zero can never be met. An upper threshold at or above 16384 can never be exceeded.
- R7: The sticky status is set at the edge where the raw bit goes from 0 to 1, provided irq_en is high in that cycle. It stays set until it is cleared. Turning irq_en on while the raw bit is already 1 does not set it.
- R8: A one-cycle high pulse on stat_clr clears the sticky status whether or not the strobe is present. When a set event and a clear occur in the same cycle, the set wins.
- R9: The interrupt output is high exactly when the sticky status and irq_en are both high.
- R10: While rst_n is low, the raw bit and the sticky status are cleared at each clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_stb | input | 1 | Compare strobe, one cycle per switching period |
| duty_a | input | 14 | Main switch duty Da, fraction of 16384 |
| duty_b | input | 14 | Sync rectifier duty Db, fraction of 16384 |
| lim_lo | input | 14 | Margin below the complement for setting |
| lim_hi | input | 14 | Margin above the complement for clearing |
| irq_en | input | 1 | Interrupt enable |
| stat_clr | input | 1 | Write-one clear of the sticky status |
| dcm_raw | output | 1 | Raw discontinuous-mode detect level |
| dcm_stat | output | 1 | Sticky interrupt status |
| dcm_irq | output | 1 | Interrupt output, status gated by enable |

## Verification
The hardest situations to reach are the thresholds that fall outside the 0 to 16384 range. One is a lower threshold below zero, with a large Da and a wide low margin. The other is an upper threshold at or above full scale, with Da near zero. These thresholds only matter when the raw bit already holds the value they could disturb. The stimulus table therefore first drives the raw bit to the needed state, then applies Db at the extreme codes 0 and 16383 against those thresholds. A further stimulus makes a new set event coincide with a clear pulse.

// File: rtl/dcm_pkg.sv
// Package: shared types for the discontinuous-conduction detector.
// Assumes: nothing beyond IEEE 1800-2017.
package dcm_pkg;

    // Decision produced by the threshold comparator for one strobe.
    typedef enum logic [1:0] {
        DEC_HOLD  = 2'b00,
        DEC_SET   = 2'b01,
        DEC_CLEAR = 2'b10
    } hyst_dec_e;

endpackage

// File: rtl/dcm_thresh_cmp.sv
// Module: dcm_thresh_cmp
// Forms the complement reference (full scale minus Da) and the lower and
// upper hysteresis thresholds in a widened signed range. It then compares
// Db against both and returns a set, clear or hold decision.
// Assumes: limits are non-negative, so the two thresholds never cross.
module dcm_thresh_cmp #(
    parameter int DUTY_W = 14
) (
    input  logic [DUTY_W-1:0] duty_a,
    input  logic [DUTY_W-1:0] duty_b,
    input  logic [DUTY_W-1:0] lim_lo,
    input  logic [DUTY_W-1:0] lim_hi,
    output dcm_pkg::hyst_dec_e dec
);
    localparam int EXT_W = DUTY_W + 3;

    logic signed [EXT_W-1:0] full_s;
    logic signed [EXT_W-1:0] comp_s;
    logic signed [EXT_W-1:0] lo_th_s;
    logic signed [EXT_W-1:0] hi_th_s;
    logic signed [EXT_W-1:0] db_s;

    // Widen operands with zero guard bits so that sums and differences cannot wrap.
    always_comb begin
        full_s  = $signed({2'b00, 1'b1, {DUTY_W{1'b0}}});
        comp_s  = full_s - $signed({3'b000, duty_a});
        lo_th_s = comp_s - $signed({3'b000, lim_lo});
        hi_th_s = comp_s + $signed({3'b000, lim_hi});
        db_s    = $signed({3'b000, duty_b});
    end

    // Strict comparisons: a value equal to either threshold gives hold.
    always_comb begin
        if (db_s < lo_th_s)
            dec = dcm_pkg::DEC_SET;
        else if (db_s > hi_th_s)
            dec = dcm_pkg::DEC_CLEAR;
        else
            dec = dcm_pkg::DEC_HOLD;
    end
endmodule

// File: rtl/dcm_hyst_state.sv
// Module: dcm_hyst_state
// Holds the raw detect bit and applies the comparator decision only on a
// strobe cycle. It also flags the cycle in which the bit is about to rise.
// Assumes: synchronous active-low reset; the strobe is at most one cycle long.
module dcm_hyst_state (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmp_stb,
    input  dcm_pkg::hyst_dec_e dec,
    output logic               raw_q,
    output logic               rise_evt
);
    logic raw_d;

    // Next raw value: the decision takes effect only under the strobe.
    always_comb begin
        raw_d = raw_q;
        if (cmp_stb) begin
            unique case (dec)
                dcm_pkg::DEC_SET:   raw_d = 1'b1;
                dcm_pkg::DEC_CLEAR: raw_d = 1'b0;
                default:            raw_d = raw_q;
            endcase
        end
    end

    // A 0-to-1 transition on the coming edge marks a new entry into the mode.
    assign rise_evt = raw_d & ~raw_q;

    // Raw detect register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_q <= 1'b0;
        else
            raw_q <= raw_d;
    end
endmodule

// File: rtl/dcm_irq_latch.sv
// Module: dcm_irq_latch
// Sticky interrupt status: set by an enabled rise event, cleared by a
// write-one pulse. A set in the same cycle as a clear wins.
// Assumes: synchronous active-low reset.
module dcm_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_evt,
    input  logic irq_en,
    input  logic stat_clr,
    output logic stat_q
);
    // Status register: the set term is given priority over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= 1'b0;
        else if (rise_evt && irq_en)
            stat_q <= 1'b1;
        else if (stat_clr)
            stat_q <= 1'b0;
    end
endmodule

// File: rtl/dcm_detector.sv
// Module: dcm_detector (top)
// Detects discontinuous conduction by comparing Db against the moving
// reference full-scale minus Da, with separate set and clear margins.
// Outputs a raw level, a sticky status and a gated interrupt.
// Assumes: one strobe per switching period, with inputs stable during the strobe cycle.
module dcm_detector #(
    parameter int DUTY_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_stb,
    input  logic [DUTY_W-1:0] duty_a,
    input  logic [DUTY_W-1:0] duty_b,
    input  logic [DUTY_W-1:0] lim_lo,
    input  logic [DUTY_W-1:0] lim_hi,
    input  logic              irq_en,
    input  logic              stat_clr,
    output logic              dcm_raw,
    output logic              dcm_stat,
    output logic              dcm_irq
);
    dcm_pkg::hyst_dec_e dec;
    logic               rise_evt;

    dcm_thresh_cmp #(.DUTY_W(DUTY_W)) u_cmp (
        .duty_a (duty_a),
        .duty_b (duty_b),
        .lim_lo (lim_lo),
        .lim_hi (lim_hi),
        .dec    (dec)
    );

    dcm_hyst_state u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_stb  (cmp_stb),
        .dec      (dec),
        .raw_q    (dcm_raw),
        .rise_evt (rise_evt)
    );

    dcm_irq_latch u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_evt (rise_evt),
        .irq_en   (irq_en),
        .stat_clr (stat_clr),
        .stat_q   (dcm_stat)
    );

    // Interrupt line: the sticky status qualified by the enable.
    assign dcm_irq = dcm_stat & irq_en;
endmodule

// File: rtl/dcm_detector_chk.sv
// Module: dcm_detector_chk
// Property checker bound to dcm_detector. It recomputes the thresholds in
// plain integer arithmetic and observes only the top-level ports.
// Assumes: DUTY_W is small enough for 32-bit integer arithmetic.
module dcm_detector_chk #(
    parameter int DUTY_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_stb,
    input logic [DUTY_W-1:0] duty_a,
    input logic [DUTY_W-1:0] duty_b,
    input logic [DUTY_W-1:0] lim_lo,
    input logic [DUTY_W-1:0] lim_hi,
    input logic              irq_en,
    input logic              stat_clr,
    input logic              dcm_raw,
    input logic              dcm_stat,
    input logic              dcm_irq
);
    localparam int FULL = 1 << DUTY_W;

    int lo_t;
    int hi_t;
    int db_i;

    // Reference thresholds in 32-bit signed integers.
    always_comb begin
        lo_t = FULL - int'(duty_a) - int'(lim_lo);
        hi_t = FULL - int'(duty_a) + int'(lim_hi);
        db_i = int'(duty_b);
    end

    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_stb && (db_i < lo_t)) |=> dcm_raw);

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_stb && (db_i > hi_t)) |=> !dcm_raw);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_stb && (db_i >= lo_t) && (db_i <= hi_t)) |=> $stable(dcm_raw));

    assert_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_stb |=> $stable(dcm_raw));

    assert_stat_needs_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dcm_stat) |-> $rose(dcm_raw));

    assert_stat_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dcm_raw) && $past(irq_en)) |-> dcm_stat);

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !dcm_irq);

    assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dcm_stat && irq_en) |-> dcm_irq);

    assert_reset_R10: assert property (@(posedge clk)
        !rst_n |=> (!dcm_raw && !dcm_stat));
endmodule

bind dcm_detector dcm_detector_chk #(.DUTY_W(DUTY_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_stb  (cmp_stb),
    .duty_a   (duty_a),
    .duty_b   (duty_b),
    .lim_lo   (lim_lo),
    .lim_hi   (lim_hi),
    .irq_en   (irq_en),
    .stat_clr (stat_clr),
    .dcm_raw  (dcm_raw),
    .dcm_stat (dcm_stat),
    .dcm_irq  (dcm_irq)
);

// File: tb/dcm_detector_test.sv
`timescale 1ns/1ps
// Bench for dcm_detector: a vector table walked by one loop, then directed
// checks for reset, strobe gating and clearing without a strobe.
module dcm_detector_test;
    localparam int W = 14;
    localparam int NV = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmp_stb = 1'b0;
    logic [W-1:0] duty_a = '0;
    logic [W-1:0] duty_b = '0;
    logic [W-1:0] lim_lo = '0;
    logic [W-1:0] lim_hi = '0;
    logic         irq_en = 1'b0;
    logic         stat_clr = 1'b0;
    logic         dcm_raw;
    logic         dcm_stat;
    logic         dcm_irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Vector fields: {Da, Db, lim_lo, lim_hi, en, clr, exp_raw, exp_stat}
    localparam logic [59:0] VEC [NV] = '{
        {14'd8192, 14'd8192,  14'd100, 14'd100, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 inside band
        {14'd8192, 14'd8092,  14'd100, 14'd100, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 equal, no set
        {14'd8192, 14'd8000,  14'd100, 14'd100, 1'b1, 1'b0, 1'b1, 1'b1}, // R2 set, R7 latch
        {14'd8192, 14'd8150,  14'd100, 14'd100, 1'b1, 1'b0, 1'b1, 1'b1}, // R4 hold high
        {14'd8192, 14'd8292,  14'd100, 14'd100, 1'b1, 1'b0, 1'b1, 1'b1}, // R3 equal, no clear
        {14'd8192, 14'd8293,  14'd100, 14'd100, 1'b1, 1'b0, 1'b0, 1'b1}, // R3 clear, R7 sticky
        {14'd8192, 14'd8293,  14'd100, 14'd100, 1'b1, 1'b1, 1'b0, 1'b0}, // R8 clear
        {14'd16000,14'd0,     14'd500, 14'd100, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 negative low th
        {14'd0,    14'd100,   14'd0,   14'd100, 1'b1, 1'b0, 1'b1, 1'b1}, // R1 full comp, set
        {14'd0,    14'd16383, 14'd0,   14'd100, 1'b1, 1'b0, 1'b1, 1'b1}, // R6 hi th above scale
        {14'd0,    14'd16383, 14'd0,   14'd0,   1'b1, 1'b0, 1'b1, 1'b1}, // R6 hi th at scale
        {14'd100,  14'd16285, 14'd0,   14'd0,   1'b1, 1'b0, 1'b0, 1'b1}, // R1 R3 clear
        {14'd8192, 14'd0,     14'd100, 14'd100, 1'b0, 1'b1, 1'b1, 1'b0}, // R7 en off, R8
        {14'd8192, 14'd8192,  14'd100, 14'd100, 1'b1, 1'b0, 1'b1, 1'b0}, // R7 late enable
        {14'd8192, 14'd16000, 14'd100, 14'd100, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 clear
        {14'd8192, 14'd0,     14'd100, 14'd100, 1'b1, 1'b1, 1'b1, 1'b1}  // R8 set wins
    };

    dcm_detector #(.DUTY_W(W)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_stb  (cmp_stb),
        .duty_a   (duty_a),
        .duty_b   (duty_b),
        .lim_lo   (lim_lo),
        .lim_hi   (lim_hi),
        .irq_en   (irq_en),
        .stat_clr (stat_clr),
        .dcm_raw  (dcm_raw),
        .dcm_stat (dcm_stat),
        .dcm_irq  (dcm_irq)
    );

    // 100 MHz clock.
    always #5 clk = ~clk;

    // Compare one output bit and report a mismatch.
    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // Reset state, R10.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", "raw after reset", dcm_raw, 1'b0);
        check("R10", "stat after reset", dcm_stat, 1'b0);
        check("R10", "irq after reset", dcm_irq, 1'b0);
        rst_n = 1'b1;

        // Table walk: drive at negedge, strobe over one posedge, check at the next negedge.
        for (int i = 0; i < NV; i++) begin
            logic [59:0] v;
            v = VEC[i];
            @(negedge clk);
            duty_a   = v[59:46];
            duty_b   = v[45:32];
            lim_lo   = v[31:18];
            lim_hi   = v[17:4];
            irq_en   = v[3];
            stat_clr = v[2];
            cmp_stb  = 1'b1;
            @(negedge clk);
            cmp_stb  = 1'b0;
            stat_clr = 1'b0;
            check("R2/R3/R4", $sformatf("raw vec %0d", i), dcm_raw, v[1]);
            check("R7/R8", $sformatf("stat vec %0d", i), dcm_stat, v[0]);
            check("R9", $sformatf("irq vec %0d", i), dcm_irq, v[0] & v[3]);
        end

        // R5: with raw and stat high, a clearing Db without a strobe does nothing.
        @(negedge clk);
        duty_a = 14'd8192;
        duty_b = 14'd16383;
        lim_hi = 14'd0;
        repeat (4) @(negedge clk);
        check("R5", "raw without strobe", dcm_raw, 1'b1);
        check("R9", "irq with stat and en", dcm_irq, 1'b1);

        // R9: dropping the enable masks the line but keeps the status.
        irq_en = 1'b0;
        @(negedge clk);
        check("R9", "irq masked", dcm_irq, 1'b0);
        check("R7", "stat kept while masked", dcm_stat, 1'b1);
        irq_en = 1'b1;

        // R8: a clear pulse without a strobe drops the status.
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
        check("R8", "stat cleared without strobe", dcm_stat, 1'b0);
        check("R8", "irq after clear", dcm_irq, 1'b0);
        check("R5", "raw untouched by clear", dcm_raw, 1'b1);

        // R10: a reset in mid-run clears the raw bit.
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", "raw after mid reset", dcm_raw, 1'b0);
        check("R10", "stat after mid reset", dcm_stat, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule